// File: doc/BRIEF.md
# USB Device Link Connection Tracker

This block follows the connection state of a full-speed USB device link. It watches two levels: a filtered bus-power sense and the pull-up enable that software drives. It also watches a set of single-cycle event strobes: bus reset, bus idle long enough to suspend, bus activity, a start-of-frame seen, a J state seen, and a software resume request. From these it keeps one of seven link states. The strobes come from neighbouring blocks; this block only interprets them.

The current state is reported as a 3-bit code. Four status flags are decoded from it: disconnected, suspended, link active and powered. Every output is registered. The state code and the flags are loaded on the same clock edge, from the state being entered, so they always agree.

Top module: `lnk_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the state code becomes 0 (off), `disconnected_o` is 1 and the other three flags are 0.
- R2: If power sense is low or pull-up enable is low at an edge, the next state is off (code 0) from any state. This check overrides every event.
- R3: From off, the state moves to powered (code 1) only when power sense and pull-up enable are both high. Otherwise it stays off.
- R4: In powered, the next state is chosen in this order. A bus reset goes to active-without-frames (code 4). Otherwise a resume request goes to waking (code 3). Otherwise bus idle goes to powered-asleep (code 2).
- R5: In powered-asleep (code 2), a bus reset goes to code 4. Otherwise bus activity returns to powered (code 1). With no event the state is held.
- R6: In waking (code 3), a J state or a bus reset goes to code 4. Otherwise the state is held.
- R7: In active-without-frames (code 4), bus idle goes to asleep (code 6). Otherwise a start-of-frame goes to active (code 5).
- R8: In active (code 5), bus idle goes to asleep (code 6). Otherwise a bus reset goes to code 4. A start-of-frame alone keeps code 5.
- R9: In asleep (code 6), a bus reset goes to code 4. Otherwise bus activity goes to waking (code 3).
- R10: The flags follow the state. `disconnected_o` is 1 only in code 0. `suspended_o` is 1 in codes 2 and 6. `link_active_o` is 1 in codes 4 and 5.
- R11: `powered_o` is 1 only when power sense is high and the state is code 1, 4 or 5. It is 0 after an edge that samples power sense low.
- R12: Inputs sampled at a rising edge appear on the state code and on all flags right after that same edge. Between edges the outputs do not change. The code never takes the value 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_sense_i | input | 1 | Filtered bus-power sense level |
| pullup_en_i | input | 1 | Pull-up enable from software |
| bus_reset_i | input | 1 | Bus reset event strobe |
| bus_idle_i | input | 1 | Bus idle (suspend-worthy) event strobe |
| bus_busy_i | input | 1 | Bus activity resumed event strobe |
| sof_seen_i | input | 1 | Start-of-frame received strobe |
| j_seen_i | input | 1 | J state detected strobe |
| resume_req_i | input | 1 | Software resume request |
| link_state_o | output | 3 | Current state code (0..6) |
| disconnected_o | output | 1 | Link is off |
| suspended_o | output | 1 | Link is in either asleep state |
| link_active_o | output | 1 | Link is active, with or without frames |
| powered_o | output | 1 | Powered indication |

## Verification
The next-state logic and the flag decode feed output registers directly. Every result is therefore due exactly one rising edge after the edge that samples its inputs.

The bench drives inputs on the falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. One test samples just before the rising edge to confirm the outputs have not moved yet.

Each priority rule is checked by raising the competing events together and checking that the higher-priority one wins.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int ST_W   = 3;
  localparam int FLAG_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_OFF       = 3'd0,
    ST_PWR       = 3'd1,
    ST_PWR_SLP   = 3'd2,
    ST_WAKE      = 3'd3,
    ST_RUN_NOSOF = 3'd4,
    ST_RUN       = 3'd5,
    ST_SLP       = 3'd6
  } lnk_st_e;

  // field order fixes the packed layout used by the flag register
  typedef struct packed {
    logic off;
    logic slp;
    logic run;
    logic pwr;
  } lnk_flags_t;

  localparam lnk_flags_t FLAGS_RST = '{off: 1'b1, slp: 1'b0, run: 1'b0, pwr: 1'b0};

endpackage

// File: rtl/lnk_reg.sv
module lnk_reg #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/lnk_next.sv
module lnk_next
  import lnk_pkg::*;
(
  input  lnk_st_e cur,
  input  logic    pwr_sense,
  input  logic    pullup_en,
  input  logic    ev_reset,
  input  logic    ev_idle,
  input  logic    ev_busy,
  input  logic    ev_sof,
  input  logic    ev_j,
  input  logic    ev_resume,
  output lnk_st_e nxt
);

  logic attached;
  assign attached = pwr_sense & pullup_en;

  always_comb begin
    nxt = cur;
    if (!attached) begin
      nxt = ST_OFF;
    end else begin
      case (cur)
        ST_OFF:       nxt = ST_PWR;
        ST_PWR: begin
          if      (ev_reset)  nxt = ST_RUN_NOSOF;
          else if (ev_resume) nxt = ST_WAKE;
          else if (ev_idle)   nxt = ST_PWR_SLP;
        end
        ST_PWR_SLP: begin
          if      (ev_reset)  nxt = ST_RUN_NOSOF;
          else if (ev_busy)   nxt = ST_PWR;
        end
        ST_WAKE: begin
          if (ev_j || ev_reset) nxt = ST_RUN_NOSOF;
        end
        ST_RUN_NOSOF: begin
          if      (ev_idle)   nxt = ST_SLP;
          else if (ev_sof)    nxt = ST_RUN;
        end
        ST_RUN: begin
          if      (ev_idle)   nxt = ST_SLP;
          else if (ev_reset)  nxt = ST_RUN_NOSOF;
        end
        ST_SLP: begin
          if      (ev_reset)  nxt = ST_RUN_NOSOF;
          else if (ev_busy)   nxt = ST_WAKE;
        end
        default:              nxt = ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/lnk_decode.sv
module lnk_decode
  import lnk_pkg::*;
(
  input  lnk_st_e    st,
  input  logic       pwr_sense,
  output lnk_flags_t fl
);

  logic running;
  assign running = (st == ST_RUN) || (st == ST_RUN_NOSOF);

  always_comb begin
    fl.off = (st == ST_OFF);
    fl.slp = (st == ST_SLP) || (st == ST_PWR_SLP);
    fl.run = running;
    fl.pwr = pwr_sense && ((st == ST_PWR) || running);
  end

endmodule

// File: rtl/lnk_tracker.sv
module lnk_tracker
  import lnk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_sense_i,
  input  logic            pullup_en_i,
  input  logic            bus_reset_i,
  input  logic            bus_idle_i,
  input  logic            bus_busy_i,
  input  logic            sof_seen_i,
  input  logic            j_seen_i,
  input  logic            resume_req_i,
  output logic [ST_W-1:0] link_state_o,
  output logic            disconnected_o,
  output logic            suspended_o,
  output logic            link_active_o,
  output logic            powered_o
);

  logic [ST_W-1:0]   st_q;
  lnk_st_e           st_cur;
  lnk_st_e           st_nxt;
  lnk_flags_t        fl_nxt;
  logic [FLAG_W-1:0] fl_q;
  lnk_flags_t        fl_cur;

  assign st_cur = lnk_st_e'(st_q);

  lnk_next u_next (
    .cur       (st_cur),
    .pwr_sense (pwr_sense_i),
    .pullup_en (pullup_en_i),
    .ev_reset  (bus_reset_i),
    .ev_idle   (bus_idle_i),
    .ev_busy   (bus_busy_i),
    .ev_sof    (sof_seen_i),
    .ev_j      (j_seen_i),
    .ev_resume (resume_req_i),
    .nxt       (st_nxt)
  );

  // flags come from the state being entered, so they land with it
  lnk_decode u_decode (
    .st        (st_nxt),
    .pwr_sense (pwr_sense_i),
    .fl        (fl_nxt)
  );

  lnk_reg #(.W(ST_W), .RST_VAL(ST_OFF)) u_st_reg (
    .clk (clk),
    .rst (rst),
    .d   (st_nxt),
    .q   (st_q)
  );

  lnk_reg #(.W(FLAG_W), .RST_VAL(FLAGS_RST)) u_fl_reg (
    .clk (clk),
    .rst (rst),
    .d   (fl_nxt),
    .q   (fl_q)
  );

  assign fl_cur         = lnk_flags_t'(fl_q);
  assign link_state_o   = st_q;
  assign disconnected_o = fl_cur.off;
  assign suspended_o    = fl_cur.slp;
  assign link_active_o  = fl_cur.run;
  assign powered_o      = fl_cur.pwr;

endmodule

// File: rtl/lnk_tracker_chk.sv
module lnk_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_sense_i,
  input logic       pullup_en_i,
  input logic       bus_reset_i,
  input logic       j_seen_i,
  input logic [2:0] link_state_o,
  input logic       disconnected_o,
  input logic       suspended_o,
  input logic       link_active_o,
  input logic       powered_o
);

  a_r2_detach_wins: assert property (@(posedge clk) disable iff (rst)
    (!pwr_sense_i || !pullup_en_i) |=> (link_state_o == 3'd0));

  a_r3_attach: assert property (@(posedge clk) disable iff (rst)
    (link_state_o == 3'd0 && pwr_sense_i && pullup_en_i) |=> (link_state_o == 3'd1));

  a_r6_wake_exit: assert property (@(posedge clk) disable iff (rst)
    (link_state_o == 3'd3 && pwr_sense_i && pullup_en_i && (j_seen_i || bus_reset_i))
      |=> (link_state_o == 3'd4));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({disconnected_o, suspended_o, link_active_o}));

  a_r10_off_flag: assert property (@(posedge clk) disable iff (rst)
    disconnected_o == (link_state_o == 3'd0));

  a_r11_powered_states: assert property (@(posedge clk) disable iff (rst)
    powered_o |-> (link_state_o == 3'd1 || link_state_o == 3'd4 || link_state_o == 3'd5));

  a_r12_code_legal: assert property (@(posedge clk) disable iff (rst)
    link_state_o != 3'd7);

endmodule

bind lnk_tracker lnk_tracker_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .pwr_sense_i    (pwr_sense_i),
  .pullup_en_i    (pullup_en_i),
  .bus_reset_i    (bus_reset_i),
  .j_seen_i       (j_seen_i),
  .link_state_o   (link_state_o),
  .disconnected_o (disconnected_o),
  .suspended_o    (suspended_o),
  .link_active_o  (link_active_o),
  .powered_o      (powered_o)
);

// File: tb/lnk_tracker_test.sv
module lnk_tracker_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sense = 1'b0, pu = 1'b0;
  logic       e_rst = 1'b0, e_idle = 1'b0, e_busy = 1'b0;
  logic       e_sof = 1'b0, e_j = 1'b0, e_res = 1'b0;
  logic [2:0] code;
  logic       f_off, f_slp, f_run, f_pwr;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  lnk_tracker uut (
    .clk (clk), .rst (rst),
    .pwr_sense_i (sense), .pullup_en_i (pu),
    .bus_reset_i (e_rst), .bus_idle_i (e_idle), .bus_busy_i (e_busy),
    .sof_seen_i (e_sof), .j_seen_i (e_j), .resume_req_i (e_res),
    .link_state_o (code), .disconnected_o (f_off), .suspended_o (f_slp),
    .link_active_o (f_run), .powered_o (f_pwr)
  );

  // expected flags {off, slp, run, pwr} from R10/R11
  function automatic logic [3:0] exp_fl(input logic [2:0] c, input logic s);
    exp_fl = {c == 3'd0, (c == 3'd2) || (c == 3'd6), (c == 3'd4) || (c == 3'd5),
              s && ((c == 3'd1) || (c == 3'd4) || (c == 3'd5))};
  endfunction

  task automatic chk(input string req, input logic [2:0] exp_c);
    logic [3:0] ef;
    ef = exp_fl(exp_c, sense);
    checks++;
    if (code !== exp_c || {f_off, f_slp, f_run, f_pwr} !== ef || code === 3'd7) begin
      errors++;
      $display("FAIL %s: state=%0d flags=%b expected state=%0d flags=%b",
               req, code, {f_off, f_slp, f_run, f_pwr}, exp_c, ef);
    end
  endtask

  // event bits {reset, idle, busy, sof, j, resume}; applied for one edge
  task automatic ev(input logic [5:0] e);
    {e_rst, e_idle, e_busy, e_sof, e_j, e_res} = e;
    @(negedge clk);
    {e_rst, e_idle, e_busy, e_sof, e_j, e_res} = 6'b0;
  endtask

  task automatic go_powered();
    sense = 1'b0; ev(6'b0);
    sense = 1'b1; pu = 1'b1; ev(6'b0);
  endtask
  task automatic go_nosof();  go_powered(); ev(6'b100000); endtask
  task automatic go_active(); go_nosof();   ev(6'b000100); endtask
  task automatic go_slp();    go_nosof();   ev(6'b010000); endtask
  task automatic go_wake();   go_powered(); ev(6'b000001); endtask
  task automatic go_pslp();   go_powered(); ev(6'b010000); endtask

  task automatic t_reset();
    sense = 1'b1; pu = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 held in reset", 3'd0);
    rst = 1'b0; sense = 1'b0;
    ev(6'b100000);
    chk("R3 no power stays off", 3'd0);
  endtask

  task automatic t_attach();
    sense = 1'b1; pu = 1'b0; ev(6'b0);
    chk("R3 pull-up low stays off", 3'd0);
    pu = 1'b1; ev(6'b0);
    chk("R3 attach to powered", 3'd1);
    chk("R11 powered flag in powered", 3'd1);
  endtask

  task automatic t_powered();
    go_powered(); ev(6'b110001);
    chk("R4 reset beats resume and idle", 3'd4);
    go_powered(); ev(6'b010001);
    chk("R4 resume beats idle", 3'd3);
    go_powered(); ev(6'b010000);
    chk("R4 idle to powered-asleep", 3'd2);
  endtask

  task automatic t_pslp();
    go_pslp(); ev(6'b000100);
    chk("R5 held without event", 3'd2);
    ev(6'b001000);
    chk("R5 activity back to powered", 3'd1);
    go_pslp(); ev(6'b101000);
    chk("R5 reset beats activity", 3'd4);
  endtask

  task automatic t_wake();
    go_wake(); ev(6'b011100);
    chk("R6 held without J or reset", 3'd3);
    ev(6'b000010);
    chk("R6 J ends waking", 3'd4);
    go_wake(); ev(6'b100000);
    chk("R6 reset ends waking", 3'd4);
  endtask

  task automatic t_nosof();
    go_nosof(); ev(6'b010100);
    chk("R7 idle beats SOF", 3'd6);
    go_nosof(); ev(6'b000100);
    chk("R7 SOF to active", 3'd5);
  endtask

  task automatic t_active();
    go_active(); ev(6'b000100);
    chk("R8 SOF keeps active", 3'd5);
    ev(6'b110000);
    chk("R8 idle beats reset", 3'd6);
    go_active(); ev(6'b100000);
    chk("R8 reset to no-frames", 3'd4);
  endtask

  task automatic t_slp();
    go_slp(); ev(6'b101000);
    chk("R9 reset beats activity", 3'd4);
    go_slp(); ev(6'b001000);
    chk("R9 activity to waking", 3'd3);
  endtask

  task automatic t_detach();
    go_active(); pu = 1'b0; ev(6'b100100);
    chk("R2 pull-up drop beats events", 3'd0);
    go_slp(); sense = 1'b0; ev(6'b101000);
    chk("R2 power loss from asleep", 3'd0);
    chk("R11 powered low without sense", 3'd0);
    go_wake(); sense = 1'b0; ev(6'b000010);
    chk("R2 power loss beats J", 3'd0);
  endtask

  task automatic t_timing();
    go_powered();
    e_idle = 1'b1;
    #3;
    chk("R12 unchanged before edge", 3'd1);
    @(negedge clk);
    e_idle = 1'b0;
    chk("R12 changed after edge", 3'd2);
    chk("R10 suspended flag in powered-asleep", 3'd2);
  endtask

  initial begin
    t_reset();
    t_attach();
    t_powered();
    t_pslp();
    t_wake();
    t_nosof();
    t_active();
    t_slp();
    t_detach();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule